// File: doc/BRIEF.md
# Register Ring Node

This block is one station on a daisy-chained register-access ring. Packets arrive on a 32-bit ring input as three back-to-back beats: a header carrying a command, a source tag and an address, then the upper and the lower 32 bits of a 64-bit data word. Every packet is passed on downstream unchanged. When a write or read request addresses one of the eight 64-bit registers held in this node, the node also performs the access and sends a response packet immediately after the forwarded request.

Inbound beats are captured on the falling clock edge and outbound beats are launched on the rising edge. An all-zero beat is idle. A small in-order output queue holds forwarded requests and responses. Every outbound packet ends with one zero beat. If the queue cannot take a packet together with its response, the packet is dropped whole and a sticky overflow flag is raised. Only reset clears the flag.

Top module: `ring_reg_node`

## Requirements
- R1: A packet starts at an inbound beat whose command field ring_in[31:29] is nonzero and occupies that beat plus the next two beats, whatever their values. An all-zero beat outside a packet is idle and is ignored.
- R2: Command codes are 1 = write request, 2 = read request, 3 = read response and 4 = write response. Code 0 is idle, and codes 5 to 7 are unsupported.
- R3: Every accepted packet is sent out bit-for-bit unchanged, in arrival order, on ring_out, as header, data[63:32] and data[31:0].
- R4: A write request (code 1) to a local address updates that register. Right after the forwarded request, the node emits a write response (code 4) with the same tag and address, whose data is the newly written register value.
- R5: A read request (code 2) to a local address produces, right after the forwarded request, a read response (code 3) with the same tag and address and the register's current contents as data.
- R6: A packet with an unmapped address, or with a code other than 1 or 2, produces no response and changes no register, but it is still forwarded.
- R7: An outbound packet uses three consecutive cycles and is always followed by one all-zero beat before the next packet.
- R8: While rst_n is low, ring_out is zero and overflow is low. Reset returns all registers to zero and empties the queue.
- R9: If the free queue space is smaller than the packet plus its response, the packet is dropped with no register effect, and overflow goes high and stays high until reset.
- R10: Traffic that leaves at least one idle beat after each non-local packet and at least five after each local request never raises overflow.
- R11: The local window is the eight addresses starting at BASE_ADDR, which is a multiple of 8, with address bits [2:0] selecting the register. The addresses BASE_ADDR-1 and BASE_ADDR+8 are outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inbound beats are taken on the falling edge, outbound beats are driven on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_in | input | 32 | Inbound ring beat |
| ring_out | output | 32 | Outbound ring beat |
| overflow | output | 1 | Sticky flag: a packet was dropped because the queue was full |

## Verification
On every cycle, the checker confirms that each outbound packet is followed by a zero beat, that a packet never opens with a zero command field, that the overflow flag never falls outside reset, and that the output stays quiet during reset. Whether a response appears, what it carries, the ordering of a request ahead of its response, address-window edges and the effect of reset on register contents depend on packet history. Only the bench's reference model, comparing every outbound packet, can show these.

// File: rtl/ring_reg_node.sv
module ring_reg_node #(
  parameter int BUS_W = 32,
  parameter int CMD_W = 3,
  parameter int TAG_W = 4,
  parameter int NREG  = 8,
  parameter int DEPTH = 4,
  parameter logic [31:0] BASE_ADDR = 32'h100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] ring_in,
  output logic [BUS_W-1:0] ring_out,
  output logic             overflow
);
  localparam int ADDR_W = BUS_W - CMD_W - TAG_W;
  localparam int DATA_W = 2 * BUS_W;
  localparam int PKT_W  = BUS_W + DATA_W;
  localparam int IDX_W  = $clog2(NREG);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = PTR_W + 1;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
  localparam logic [CMD_W-1:0] C_WREQ = CMD_W'(1);
  localparam logic [CMD_W-1:0] C_RREQ = CMD_W'(2);
  localparam logic [CMD_W-1:0] C_RRSP = CMD_W'(3);
  localparam logic [CMD_W-1:0] C_WRSP = CMD_W'(4);

  // inbound deserializer, falling edge
  logic [1:0]       in_beat;
  logic [BUS_W-1:0] in_hdr, in_hi;
  logic [PKT_W-1:0] rx_pkt;
  logic             rx_vld;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      in_beat <= '0;
      in_hdr  <= '0;
      in_hi   <= '0;
      rx_pkt  <= '0;
      rx_vld  <= 1'b0;
    end else begin
      rx_vld <= 1'b0;
      case (in_beat)
        2'd0: if (ring_in[BUS_W-1 -: CMD_W] != '0) begin
          in_hdr  <= ring_in;
          in_beat <= 2'd1;
        end
        2'd1: begin
          in_hi   <= ring_in;
          in_beat <= 2'd2;
        end
        default: begin
          rx_pkt  <= {in_hdr, in_hi, ring_in};
          rx_vld  <= 1'b1;
          in_beat <= 2'd0;
        end
      endcase
    end

  // decode
  logic [DATA_W-1:0] regs [NREG];
  wire [CMD_W-1:0]  rx_cmd  = rx_pkt[PKT_W-1 -: CMD_W];
  wire [ADDR_W-1:0] rx_addr = rx_pkt[DATA_W +: ADDR_W];
  wire [DATA_W-1:0] rx_data = rx_pkt[DATA_W-1:0];
  wire [IDX_W-1:0]  idx     = rx_addr[IDX_W-1:0];
  wire              hit     = rx_addr[ADDR_W-1:IDX_W] == BASE[ADDR_W-1:IDX_W];
  wire              is_wr   = hit && (rx_cmd == C_WREQ);
  wire              is_rd   = hit && (rx_cmd == C_RREQ);
  wire              has_rsp = is_wr || is_rd;
  wire [DATA_W-1:0] rsp_data = is_wr ? rx_data : regs[idx];
  wire [PKT_W-1:0]  rsp_pkt  = {is_wr ? C_WRSP : C_RRSP,
                                rx_pkt[PKT_W-CMD_W-1:DATA_W], rsp_data};

  // output queue
  logic [PKT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;
  logic [1:0]       out_ph;
  logic [PKT_W-1:0] cur;

  wire [CNT_W-1:0] need   = has_rsp ? CNT_W'(2) : CNT_W'(1);
  wire             fits   = (CNT_W'(DEPTH) - count) >= need;
  wire             push   = rx_vld && fits;
  wire             pop    = (out_ph == 2'd0) && (count != '0);
  wire [CNT_W-1:0] push_n = push ? need : '0;

  always_ff @(posedge clk)
    if (push) begin
      mem[wptr] <= rx_pkt;
      if (has_rsp) mem[wptr + PTR_W'(1)] <= rsp_pkt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (push) begin
        wptr <= wptr + PTR_W'(push_n);
        if (is_wr) regs[idx] <= rx_data;
      end
      if (rx_vld && !fits) overflow <= 1'b1;
      count <= count + push_n - CNT_W'(pop);
    end

  // outbound serializer, rising edge
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rptr     <= '0;
      out_ph   <= '0;
      cur      <= '0;
      ring_out <= '0;
    end else begin
      case (out_ph)
        2'd0: if (pop) begin
          ring_out <= mem[rptr][PKT_W-1 -: BUS_W];
          cur      <= mem[rptr];
          rptr     <= rptr + PTR_W'(1);
          out_ph   <= 2'd1;
        end else ring_out <= '0;
        2'd1: begin
          ring_out <= cur[DATA_W-1 -: BUS_W];
          out_ph   <= 2'd2;
        end
        2'd2: begin
          ring_out <= cur[BUS_W-1:0];
          out_ph   <= 2'd3;
        end
        default: begin
          ring_out <= '0;
          out_ph   <= 2'd0;
        end
      endcase
    end
endmodule

// File: rtl/ring_reg_node_chk.sv
module ring_reg_node_chk #(
  parameter int BUS_W = 32,
  parameter int CMD_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BUS_W-1:0] ring_out,
  input logic             overflow
);
  logic [1:0] ocnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ocnt <= '0;
    else if (ocnt == 2'd0) begin
      if (ring_out != '0) ocnt <= 2'd1;
    end else ocnt <= ocnt + 2'd1;

  always @(negedge clk)
    if (!rst_n) AST_RST_QUIET: assert (ring_out == '0 && !overflow); // R8

  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ocnt == 2'd3) |-> (ring_out == '0)); // R7

  AST_START_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (ocnt == 2'd0 && ring_out != '0) |-> (ring_out[BUS_W-1 -: CMD_W] != '0)); // R1

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
endmodule

bind ring_reg_node ring_reg_node_chk #(.BUS_W(BUS_W), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_out(ring_out), .overflow(overflow));

// File: tb/ring_reg_node_tb.sv
module ring_reg_node_tb;
  localparam int CLK_P = 10;
  localparam logic [24:0] BASE = 25'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ring_in = '0;
  logic [31:0] ring_out;
  logic overflow;

  int tests = 0, fails = 0;
  logic [63:0] model [8];
  logic [95:0] expq [$];
  bit track = 1'b1;
  int mph = 0;
  logic [31:0] mhdr, mhi;

  always #(CLK_P/2) clk = ~clk;

  ring_reg_node u_dut (.clk(clk), .rst_n(rst_n), .ring_in(ring_in),
                       .ring_out(ring_out), .overflow(overflow));

  function automatic logic [95:0] pk(input logic [2:0] c, input logic [3:0] t,
                                     input logic [24:0] a, input logic [63:0] d);
    return {c, t, a, d};
  endfunction

  function automatic bit mapped(input logic [24:0] a);
    return a[24:3] == BASE[24:3];
  endfunction

  task automatic check(input bit ok, input string rq, input logic [95:0] act, input logic [95:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c, input logic [3:0] t, input logic [24:0] a,
                      input logic [63:0] d, input int gap);
    if (track) begin
      expq.push_back(pk(c, t, a, d));                       // R3
      if (mapped(a) && c == 3'd1) begin                    // R4
        model[a[2:0]] = d;
        expq.push_back(pk(3'd4, t, a, d));
      end else if (mapped(a) && c == 3'd2)                 // R5
        expq.push_back(pk(3'd3, t, a, model[a[2:0]]));
    end
    @(posedge clk); #1 ring_in = {c, t, a};
    @(posedge clk); #1 ring_in = d[63:32];
    @(posedge clk); #1 ring_in = d[31:0];
    for (int g = 0; g < gap; g++) begin
      @(posedge clk); #1 ring_in = '0;
    end
  endtask

  task automatic drain(input string rq);
    repeat (60) @(negedge clk);
    check(expq.size() == 0 && mph == 0, rq, 96'(expq.size()), 96'd0);
  endtask

  always @(negedge clk) begin
    logic [95:0] got, e;
    if (!rst_n) mph = 0;
    else case (mph)
      0: if (ring_out != '0) begin mhdr = ring_out; mph = 1; end
      1: begin mhi = ring_out; mph = 2; end
      2: begin
        got = {mhdr, mhi, ring_out};
        if (track) begin
          if (expq.size() == 0) check(1'b0, "R6 unexpected packet", got, 96'd0);
          else begin
            e = expq.pop_front();
            check(got == e, e[95:93] == 3'd4 ? "R4 write response" :
                            e[95:93] == 3'd3 ? "R5 read response" : "R3 forwarded packet",
                  got, e);
          end
        end
        mph = 3;
      end
      default: begin
        check(ring_out == '0, "R7 idle beat after packet", 96'(ring_out), 96'd0);
        mph = 0;
      end
    endcase
  end

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2:0] c;
    logic [24:0] a;
    int r;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(ring_out == '0, "R8 output zero in reset", 96'(ring_out), 96'd0);
    check(!overflow, "R8 overflow low in reset", 96'(overflow), 96'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1 zero data beats still belong to the packet; R11 window edges
    send(3'd1, 4'h3, BASE, 64'd0, 8);
    send(3'd1, 4'h5, BASE + 25'd7, 64'hDEAD_BEEF_0123_4567, 8);
    send(3'd2, 4'h6, BASE + 25'd7, 64'h0, 8);
    send(3'd2, 4'h7, BASE, 64'hFFFF_FFFF_FFFF_FFFF, 8);
    // R6 R11 outside the window
    send(3'd1, 4'h1, BASE - 25'd1, 64'h1111_2222_3333_4444, 2);
    send(3'd2, 4'h2, BASE + 25'd8, 64'h5, 2);
    // R2 response and unsupported codes are forwarded only
    send(3'd3, 4'h9, BASE + 25'd1, 64'hAAAA, 2);
    send(3'd4, 4'hA, BASE + 25'd1, 64'hBBBB, 2);
    send(3'd5, 4'hB, BASE + 25'd1, 64'hCCCC, 2);
    send(3'd7, 4'hC, BASE + 25'd1, 64'hDDDD, 2);
    send(3'd2, 4'hD, BASE + 25'd1, 64'h0, 8);
    send(3'd1, 4'hE, BASE + 25'd2, 64'h0000_0001_0000_0000, 8);
    send(3'd2, 4'hF, BASE + 25'd2, 64'h0, 8);
    drain("R6 no extra packets after directed run");

    // R10 random nominal traffic
    for (int i = 0; i < 120; i++) begin
      r = int'($urandom % 10);
      c = (r < 4) ? 3'd1 : (r < 8) ? 3'd2 : 3'(3 + $urandom % 5);
      a = ($urandom % 5 != 0) ? BASE + 25'($urandom % 8) : 25'($urandom);
      send(c, 4'($urandom), a, {$urandom, $urandom},
           (mapped(a) && (c == 3'd1 || c == 3'd2)) ? 5 + int'($urandom % 3) : 1 + int'($urandom % 3));
    end
    drain("R6 no extra packets after random run");
    check(!overflow, "R10 nominal traffic never overflows", 96'(overflow), 96'd0);

    // R9 burst of local writes with one idle beat
    track = 1'b0;
    for (int i = 0; i < 10; i++) send(3'd1, 4'h4, BASE + 25'd1, 64'h77 + 64'(i), 1);
    @(negedge clk);
    check(overflow, "R9 overflow raised on full queue", 96'(overflow), 96'd1);
    repeat (40) @(negedge clk);
    check(overflow, "R9 overflow sticky", 96'(overflow), 96'd1);

    // R8 reset clears flag, queue and registers
    @(posedge clk); #1 rst_n = 1'b0;
    expq.delete();
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    check(ring_out == '0, "R8 output zero in reset", 96'(ring_out), 96'd0);
    check(!overflow, "R8 overflow cleared by reset", 96'(overflow), 96'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    track = 1'b1;
    for (int i = 0; i < 8; i++) send(3'd2, 4'(i), BASE + 25'(i), 64'h0, 6);
    drain("R8 registers read as zero after reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule